// File: doc/BRIEF.md
# Parallel Display Bus Host (6800-style)

This block is the host side of a 6800-style parallel link to a display controller. It drives one register-select line, a read/write line, an enable line, an active-low chip select and a data bus. The data bus is split into an output word, an output enable and an input word, so the pad ring can build the tri-state buffer. A user-side request port starts one transfer at a time: a command or data write, or a single read. When the transfer is complete, the port gives a one-cycle acknowledge and, for a read, the captured word.

Every bus timing minimum is given as a parameter in picoseconds. Some minimums also depend on the controller's own clock period, and that period is a parameter too. Each minimum is rounded up to a whole number of host clock cycles. The strobe can be the enable line or the chip select, chosen at build time.

The inactive gap between two strobe pulses depends on the pair of transfers. A write followed by a write needs only a short gap. Any pair that involves a read needs a much longer gap. The host learns the type of the next transfer only when it is requested, so it tops up the gap during that transfer's setup phase.

Top module: `pbus_host`

## Requirements
- R1: After reset the chip select is high, the data output enable is low, the acknowledge is low and the read word is zero. In enable-strobe mode the enable line is low; in chip-select-strobe mode it is high.
- R2: A write drives the read/write line low (0 = write) and the register-select line to the requested value. It drives the captured write word with the output enable high. The strobe is active for WR_CYC cycles, where WR_CYC = ceil(max(1.5 controller periods, 13 ns) / host period).
- R3: A read drives the read/write line high (1 = read). The strobe is active for RD_CYC cycles, where RD_CYC = ceil(max(3.5 controller periods, 30 ns, 32 ns access) / host period). The read word equals the bus input present in the last active strobe cycle, and it holds that value until the next read completes.
- R4: Register-select, read/write, output enable and the write word are already at their transfer values in the cycle before the strobe becomes active.
- R5: In the first cycle after the strobe ends, register-select, read/write and output enable keep their values. In enable-strobe mode the chip select also stays low in that cycle.
- R6: Between a write pulse and the next write pulse, the strobe stays inactive for at least FAST_CYC = ceil(max(1.5 controller periods, 13 ns) / host period) cycles.
- R7: When either pulse of a pair belongs to a read, the strobe stays inactive for at least SLOW_CYC = ceil(max(9 controller periods, 80 ns) / host period) cycles between them.
- R8: The acknowledge is high for exactly one cycle per transfer. That cycle is inactive strobe cycle number max(G, HOLD_CYC + 1) after the pulse, counting the first cycle after the pulse as 1. G is SLOW_CYC after a read and FAST_CYC after a write.
- R9: With the enable line as strobe, the enable pulse sits inside a chip-select low window that covers setup, pulse and hold. With the chip select as strobe, the enable line stays high and the chip select pulses low.
- R10: During a read the output enable is low in every strobe-active cycle and in the cycle before the strobe starts.
- R11: The host takes a request only when it is idle. Request pulses, or changes to the request fields, while a transfer is in progress have no effect, so each accepted request gives exactly one strobe pulse and one acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| req_dc | input | 1 | Register-select value for the transfer |
| req_wdata | input | DW | Word to write |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Last word read |
| bus_a0 | output | 1 | Register-select line |
| bus_rw | output | 1 | Direction line, 1 = read |
| bus_e | output | 1 | Enable line |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_d_o | output | DW | Data bus output word |
| bus_d_oe | output | 1 | Data bus output enable |
| bus_d_i | input | DW | Data bus input word |

## Verification
The bench runs a sequence that covers all four transition pairs: write after write, write after read, read after write and read after read. It runs the sequence on two instances, one for each strobe choice, and measures each gap and each pulse width in cycles against the rounded-up formulas. A host that always applied the short gap would start a read only about six cycles after a write, and one that rounded down would shorten the pulses. Stray request pulses with scrambled fields are sent while a transfer is running. A host that accepted them would produce an extra pulse and acknowledge, or would show the wrong word on the bus. The bus input changes every cycle, so a read that sampled one cycle early or late would return a different word.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_SETUP   = 3'd1,
      PH_ACTIVE  = 3'd2,
      PH_HOLD    = 3'd3,
      PH_RECOVER = 3'd4
   } phase_t;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // picoseconds to host cycles, rounded up, never below one cycle
   function automatic int cyc_of(input int ps, input int clk_ps);
      int c;
      c = (ps + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

endpackage

// File: rtl/pbus_gap_track.sv
module pbus_gap_track
   import pbus_pkg::*;
#(
   parameter int FAST_CYC = 4,
   parameter int SLOW_CYC = 23
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_act,
   input  logic cur_rd,
   output logic gap_ok
);

   localparam int GW = $clog2(SLOW_CYC + 1);

   logic [GW-1:0] gap_q;
   logic          last_rd_q;
   logic [GW:0]   gap_nx;
   logic [GW:0]   need_w;

   // inactive cycles since the last pulse, saturating at the long gap
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q     <= GW'(SLOW_CYC);
         last_rd_q <= 1'b0;
      end else if (strobe_act) begin
         gap_q     <= '0;
         last_rd_q <= cur_rd;
      end else if (gap_q != GW'(SLOW_CYC)) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   // a read on either side of the gap asks for the long recovery
   assign need_w = (cur_rd || last_rd_q) ? (GW+1)'(SLOW_CYC) : (GW+1)'(FAST_CYC);
   assign gap_nx = {1'b0, gap_q} + (GW+1)'(1);
   assign gap_ok = (gap_nx >= need_w);

   AST_GAP_MET: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_act && !$past(strobe_act)) |-> ($past(gap_nx) >= $past(need_w))); // R7

   AST_GAP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_act && !$past(strobe_act)) |-> ($past(gap_nx) >= (GW+1)'(FAST_CYC))); // R6

endmodule

// File: rtl/pbus_phase_ctrl.sv
module pbus_phase_ctrl
   import pbus_pkg::*;
#(
   parameter int SU_CYC = 1,
   parameter int HD_CYC = 1,
   parameter int WR_CYC = 4,
   parameter int RD_CYC = 9,
   parameter int SLOW_CYC = 23
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_valid,
   input  logic   req_rd,
   input  logic   gap_ok,
   output phase_t phase,
   output logic   op_rd,
   output logic   take,
   output logic   last_act,
   output logic   ack
);

   localparam int TOP = max_i(max_i(max_i(SU_CYC, HD_CYC), max_i(WR_CYC, RD_CYC)), SLOW_CYC);
   localparam int CW  = $clog2(TOP + 1);

   phase_t        phase_q, nxt;
   logic [CW-1:0] cnt;
   logic [CW:0]   cnt_nx;
   logic [CW-1:0] len_m1;
   logic          op_rd_q;

   assign cnt_nx = {1'b0, cnt} + (CW+1)'(1);
   assign len_m1 = op_rd_q ? CW'(RD_CYC - 1) : CW'(WR_CYC - 1);

   always_comb begin
      nxt      = phase_q;
      take     = 1'b0;
      last_act = 1'b0;
      ack      = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (req_valid) begin
               nxt  = PH_SETUP;
               take = 1'b1;
            end
         end
         PH_SETUP: begin
            if ((cnt_nx >= (CW+1)'(SU_CYC)) && gap_ok) nxt = PH_ACTIVE;
         end
         PH_ACTIVE: begin
            if (cnt == len_m1) begin
               nxt      = PH_HOLD;
               last_act = 1'b1;
            end
         end
         PH_HOLD: begin
            if (cnt == CW'(HD_CYC - 1)) nxt = PH_RECOVER;
         end
         PH_RECOVER: begin
            if (gap_ok) begin
               nxt = PH_IDLE;
               ack = 1'b1;
            end
         end
         default: nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt     <= '0;
         op_rd_q <= 1'b0;
      end else begin
         phase_q <= nxt;
         if (nxt != phase_q)      cnt <= '0;
         else if (cnt != CW'(TOP)) cnt <= cnt + 1'b1;
         if (take) op_rd_q <= req_rd;
      end
   end

   assign phase = phase_q;
   assign op_rd = op_rd_q;

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack); // R8

   AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (phase == PH_IDLE)); // R8

   AST_BUSY_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase != PH_IDLE) && (nxt != PH_IDLE)) |=> $stable(op_rd)); // R11

endmodule

// File: rtl/pbus_pin_drive.sv
module pbus_pin_drive
   import pbus_pkg::*;
#(
   parameter int DW           = 8,
   parameter bit STROBE_ON_CS = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  phase_t        phase,
   input  logic          op_rd,
   input  logic          take,
   input  logic          last_act,
   input  logic          req_dc,
   input  logic [DW-1:0] req_wdata,
   input  logic [DW-1:0] bus_d_i,
   output logic          bus_a0,
   output logic          bus_rw,
   output logic          bus_e,
   output logic          bus_cs_n,
   output logic [DW-1:0] bus_d_o,
   output logic          bus_d_oe,
   output logic [DW-1:0] rsp_rdata
);

   logic          a0_q;
   logic [DW-1:0] wd_q;
   logic [DW-1:0] rd_q;
   logic          framed;
   logic          strobe;
   logic          pulse;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a0_q <= 1'b0;
         wd_q <= '0;
         rd_q <= '0;
      end else begin
         if (take) begin
            a0_q <= req_dc;
            wd_q <= req_wdata;
         end
         if (last_act && op_rd) rd_q <= bus_d_i;
      end
   end

   assign framed    = (phase == PH_SETUP) || (phase == PH_ACTIVE) || (phase == PH_HOLD);
   assign strobe    = (phase == PH_ACTIVE);
   assign bus_a0    = a0_q;
   assign bus_rw    = framed ? op_rd : 1'b1;
   assign bus_d_oe  = framed && !op_rd;
   assign bus_d_o   = wd_q;
   assign rsp_rdata = rd_q;

   generate
      if (STROBE_ON_CS) begin : g_cs_strobe
         assign bus_e    = 1'b1;
         assign bus_cs_n = !strobe;
         assign pulse    = !bus_cs_n;
      end else begin : g_e_strobe
         assign bus_e    = strobe;
         assign bus_cs_n = !framed;
         assign pulse    = bus_e;

         AST_E_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
            bus_e |-> (!bus_cs_n && !$past(bus_cs_n))); // R9
      end
   endgenerate

   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && bus_rw) |-> (!bus_d_oe && !$past(bus_d_oe))); // R10

   AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse) |-> ($stable(bus_a0) && $stable(bus_rw) && $stable(bus_d_oe) && $stable(bus_d_o))); // R4

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse) |-> ($stable(bus_a0) && $stable(bus_rw) && $stable(bus_d_oe))); // R5

   AST_RDATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse |=> $stable(rsp_rdata)); // R3

endmodule

// File: rtl/pbus_host.sv
module pbus_host
   import pbus_pkg::*;
#(
   parameter int DW            = 8,
   parameter int HOST_CLK_PS   = 4000,
   parameter int CTRL_CLK_PS   = 10000,
   parameter bit STROBE_ON_CS  = 1'b0,
   parameter int WR_PULSE_PS   = 13000,
   parameter int RD_PULSE_PS   = 30000,
   parameter int RD_ACCESS_PS  = 32000,
   parameter int GAP_WW_PS     = 13000,
   parameter int GAP_RD_PS     = 80000,
   parameter int ADDR_SETUP_PS = 2000,
   parameter int ADDR_HOLD_PS  = 2000,
   parameter int DATA_SETUP_PS = 4000,
   parameter int DATA_HOLD_PS  = 1000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_rd,
   input  logic          req_dc,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ack,
   output logic [DW-1:0] rsp_rdata,
   output logic          bus_a0,
   output logic          bus_rw,
   output logic          bus_e,
   output logic          bus_cs_n,
   output logic [DW-1:0] bus_d_o,
   output logic          bus_d_oe,
   input  logic [DW-1:0] bus_d_i
);

   localparam int CTRL_1P5_PS = (3 * CTRL_CLK_PS + 1) / 2;
   localparam int CTRL_3P5_PS = (7 * CTRL_CLK_PS + 1) / 2;
   localparam int WR_CYC   = cyc_of(max_i(CTRL_1P5_PS, WR_PULSE_PS), HOST_CLK_PS);
   localparam int RD_CYC   = cyc_of(max_i(max_i(CTRL_3P5_PS, RD_PULSE_PS), RD_ACCESS_PS), HOST_CLK_PS);
   localparam int FAST_CYC = cyc_of(max_i(CTRL_1P5_PS, GAP_WW_PS), HOST_CLK_PS);
   localparam int SLOW_CYC = max_i(FAST_CYC, cyc_of(max_i(9 * CTRL_CLK_PS, GAP_RD_PS), HOST_CLK_PS));
   localparam int SU_CYC   = cyc_of(max_i(ADDR_SETUP_PS, DATA_SETUP_PS), HOST_CLK_PS);
   localparam int HD_CYC   = cyc_of(max_i(ADDR_HOLD_PS, DATA_HOLD_PS), HOST_CLK_PS);

   initial begin
      assert (DW >= 1) else $error("pbus_host: DW must be at least 1");
      assert (HOST_CLK_PS > 0 && CTRL_CLK_PS > 0) else $error("pbus_host: clock periods must be positive");
      assert (RD_CYC * HOST_CLK_PS >= RD_ACCESS_PS) else $error("pbus_host: read pulse shorter than access time");
      assert (SLOW_CYC >= FAST_CYC) else $error("pbus_host: long gap below short gap");
   end

   phase_t phase;
   logic   op_rd;
   logic   take;
   logic   last_act;
   logic   gap_ok;

   pbus_phase_ctrl #(
      .SU_CYC   (SU_CYC),
      .HD_CYC   (HD_CYC),
      .WR_CYC   (WR_CYC),
      .RD_CYC   (RD_CYC),
      .SLOW_CYC (SLOW_CYC)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_rd    (req_rd),
      .gap_ok    (gap_ok),
      .phase     (phase),
      .op_rd     (op_rd),
      .take      (take),
      .last_act  (last_act),
      .ack       (req_ack)
   );

   pbus_gap_track #(
      .FAST_CYC (FAST_CYC),
      .SLOW_CYC (SLOW_CYC)
   ) u_gap (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe_act (phase == PH_ACTIVE),
      .cur_rd     (op_rd),
      .gap_ok     (gap_ok)
   );

   pbus_pin_drive #(
      .DW           (DW),
      .STROBE_ON_CS (STROBE_ON_CS)
   ) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (phase),
      .op_rd     (op_rd),
      .take      (take),
      .last_act  (last_act),
      .req_dc    (req_dc),
      .req_wdata (req_wdata),
      .bus_d_i   (bus_d_i),
      .bus_a0    (bus_a0),
      .bus_rw    (bus_rw),
      .bus_e     (bus_e),
      .bus_cs_n  (bus_cs_n),
      .bus_d_o   (bus_d_o),
      .bus_d_oe  (bus_d_oe),
      .rsp_rdata (rsp_rdata)
   );

endmodule

// File: tb/sim_pbus_host.sv
`timescale 1ns/1ps
module sim_pbus_host;

   localparam int DW = 8;
   localparam int H  = 4000;
   localparam int C  = 10000;

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
   function automatic int cdiv(input int a, input int b);
      int c;
      c = (a + b - 1) / b;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int E_WR   = cdiv(mx((3 * C + 1) / 2, 13000), H);
   localparam int E_RD   = cdiv(mx(mx((7 * C + 1) / 2, 30000), 32000), H);
   localparam int E_FAST = cdiv(mx((3 * C + 1) / 2, 13000), H);
   localparam int E_SLOW = cdiv(mx(9 * C, 80000), H);
   localparam int E_HD   = cdiv(mx(2000, 1000), H);
   localparam int NOPS   = 24;
   localparam logic [NOPS-1:0] RD_SEQ = 24'b0110_0111_0100_1011_0001_1010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_rd = 1'b0, req_dc = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic [DW-1:0] din = 8'h11;

   logic [1:0] ack_w, a0_w, rw_w, e_w, csn_w, oe_w;
   logic [DW-1:0] do_w [2];
   logic [DW-1:0] rdat_w [2];

   always #2 clk = ~clk;
   always @(posedge clk) din <= din + 8'h3b;

   pbus_host #(.DW(DW), .HOST_CLK_PS(H), .CTRL_CLK_PS(C), .STROBE_ON_CS(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd), .req_dc(req_dc),
      .req_wdata(req_wdata), .req_ack(ack_w[0]), .rsp_rdata(rdat_w[0]), .bus_a0(a0_w[0]),
      .bus_rw(rw_w[0]), .bus_e(e_w[0]), .bus_cs_n(csn_w[0]), .bus_d_o(do_w[0]),
      .bus_d_oe(oe_w[0]), .bus_d_i(din));

   pbus_host #(.DW(DW), .HOST_CLK_PS(H), .CTRL_CLK_PS(C), .STROBE_ON_CS(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd), .req_dc(req_dc),
      .req_wdata(req_wdata), .req_ack(ack_w[1]), .rsp_rdata(rdat_w[1]), .bus_a0(a0_w[1]),
      .bus_rw(rw_w[1]), .bus_e(e_w[1]), .bus_cs_n(csn_w[1]), .bus_d_o(do_w[1]),
      .bus_d_oe(oe_w[1]), .bus_d_i(din));

   logic [1:0] pulse;
   assign pulse[0] = e_w[0];
   assign pulse[1] = !csn_w[1];

   int n_chk = 0, n_fail = 0;
   bit mon_en = 0, timeout = 0;
   bit exp_rd = 0, exp_dc = 0;
   logic [DW-1:0] exp_wd = '0;
   logic [DW-1:0] exp_rdata [2] = '{default: '0};
   logic [DW-1:0] rec_din [2] = '{default: '0};
   int inact [2] = '{default: 0};
   int act_len [2] = '{default: 0};
   int n_ack [2] = '{default: 0};
   int n_pulse [2] = '{default: 0};
   bit seen [2] = '{default: 0};
   bit last_rd [2] = '{default: 0};
   logic [1:0] prev_pulse = '0, prev_a0 = '0, prev_rw = '1, prev_oe = '0;
   bit bad_frame = 0, bad_park = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      int need, expack;
      if (rst_n && mon_en) begin
         for (int i = 0; i < 2; i++) begin
            if (pulse[i]) begin
               if (!prev_pulse[i]) begin
                  n_pulse[i]++;
                  chk(rw_w[i] == exp_rd, exp_rd ? "R3 rw" : "R2 rw", rw_w[i], exp_rd);
                  chk(a0_w[i] == exp_dc, "R2 a0", a0_w[i], exp_dc);
                  if (!exp_rd) chk(oe_w[i] && (do_w[i] == exp_wd), "R2 data", do_w[i], exp_wd);
                  else chk(!oe_w[i] && !prev_oe[i], "R10 oe", oe_w[i], 0);
                  chk((prev_a0[i] == a0_w[i]) && (prev_rw[i] == rw_w[i]), "R4 setup", prev_a0[i], a0_w[i]);
                  if (seen[i]) begin
                     need = (exp_rd || last_rd[i]) ? E_SLOW : E_FAST;
                     chk(inact[i] >= need, (need == E_SLOW) ? "R7 gap" : "R6 gap", inact[i], need);
                  end
                  act_len[i] = 0;
               end
               act_len[i]++;
               rec_din[i] = din;
               inact[i] = 0;
               if (exp_rd) chk(!oe_w[i], "R10 oe active", oe_w[i], 0);
            end else begin
               if (prev_pulse[i]) begin
                  chk(act_len[i] == (exp_rd ? E_RD : E_WR), exp_rd ? "R3 width" : "R2 width",
                      act_len[i], exp_rd ? E_RD : E_WR);
                  chk((a0_w[i] == prev_a0[i]) && (rw_w[i] == prev_rw[i]) && (oe_w[i] == prev_oe[i]),
                      "R5 hold", {a0_w[i], rw_w[i], oe_w[i]}, {prev_a0[i], prev_rw[i], prev_oe[i]});
                  if (i == 0) chk(!csn_w[0], "R5 cs hold", csn_w[0], 0);
                  last_rd[i] = exp_rd;
                  seen[i] = 1;
                  if (exp_rd) exp_rdata[i] = rec_din[i];
               end
               inact[i]++;
            end
            if (ack_w[i]) begin
               n_ack[i]++;
               need = exp_rd ? E_SLOW : E_FAST;
               expack = mx(need, E_HD + 1);
               chk(inact[i] == expack, "R8 ack cycle", inact[i], expack);
               chk(rdat_w[i] == exp_rdata[i], "R3 rdata", rdat_w[i], exp_rdata[i]);
            end
            if (i == 0 && e_w[0] && csn_w[0]) bad_frame = 1;
            if (i == 1 && !e_w[1]) bad_park = 1;
            prev_pulse[i] = pulse[i];
            prev_a0[i] = a0_w[i];
            prev_rw[i] = rw_w[i];
            prev_oe[i] = oe_w[i];
         end
      end
   end

   task automatic issue(input bit rd, input bit dc, input logic [DW-1:0] wd);
      int w;
      @(posedge clk); #1;
      req_valid = 1; req_rd = rd; req_dc = dc; req_wdata = wd;
      exp_rd = rd; exp_dc = dc; exp_wd = wd;
      @(posedge clk); #1;
      req_valid = 0; req_rd = !rd; req_dc = !dc; req_wdata = ~wd;
      @(posedge clk); #1;
      req_valid = 1;                       // R11 stray request while busy
      @(posedge clk); #1;
      req_valid = 0;
      w = 0;
      while (!ack_w[0] && w < 400) begin
         @(negedge clk);
         w++;
      end
      if (w >= 400) begin
         chk(0, "R8 watchdog", w, 400);
         timeout = 1;
      end
   endtask

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk(csn_w[0] && !e_w[0] && !oe_w[0] && !ack_w[0] && rdat_w[0] == '0, "R1 reset E-mode",
          {csn_w[0], e_w[0], oe_w[0], ack_w[0]}, 4'b1000);
      chk(csn_w[1] && e_w[1] && !oe_w[1] && !ack_w[1] && rdat_w[1] == '0, "R1 reset CS-mode",
          {csn_w[1], e_w[1], oe_w[1], ack_w[1]}, 4'b1100);
      mon_en = 1;
      for (int k = 0; k < NOPS; k++) begin
         if (!timeout) issue(RD_SEQ[k], k[0], DW'(k * 37 + 5));
      end
      repeat (4) @(negedge clk);
      for (int i = 0; i < 2; i++) begin
         chk(n_ack[i] == NOPS, "R11 ack count", n_ack[i], NOPS);
         chk(n_pulse[i] == NOPS, "R11 pulse count", n_pulse[i], NOPS);
      end
      chk(!bad_frame, "R9 enable inside select", bad_frame, 0);
      chk(!bad_park, "R9 enable parked high", bad_park, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule